// File: doc/BRIEF.md
# Hashed Direct-Mapped Page Descriptor Cache

This block sits beside an address translator and keeps recently used page descriptors close at hand, so that most translations finish without a trip to descriptor memory. A lookup is keyed by the segment number joined with the page number, which are the upper bits of a virtual address. The table is direct-mapped with a power-of-two number of slots. The slot for a key comes from a fixed XOR folding network, not from the low key bits, so that keys which differ only in their upper bits still spread across the table. Each slot holds a valid bit, the full key as its tag, and the cached descriptor.

On a hit the descriptor comes back one cycle after the request. On a miss the block raises stall and asks descriptor memory for the missing entry through a request/acknowledge refill handshake. It then overwrites the indexed slot with the returned descriptor and completes the lookup as a hit. Two kinds of invalidation are supported: one clears the whole table, and the other clears a single slot only when that slot holds the named key. When the translator changes a descriptor's flags, it writes the new value through an update port, so the cached copy matches memory.

Top module: `desc_cache`

## Requirements
- R1: While reset is high and in the first cycle after it, lk_hit, lk_stall and fill_req are low, and every slot is invalid, so the first lookup of any key misses.
- R2: With H index bits, index bit i is the XOR of every key bit j with j mod H equal to i. The key width must be at least 3·H, so each index bit folds at least three key bits. Two keys with the same index evict each other, and keys with different indices can be held together.
- R3: A request is accepted when lk_valid is high and lk_stall is low. If its key matches a valid slot, then in the next cycle lk_hit is 1, lk_stall is 0 and lk_desc carries that slot's descriptor.
- R4: If an accepted key does not match a valid slot, then in the next cycle lk_stall is 1, lk_hit is 0, fill_req is 1 and fill_key equals the key. All three stay unchanged until fill_ack is sampled high.
- R5: When fill_ack is sampled high while fill_req is high, the indexed slot is written with the pending key and fill_desc, and becomes valid. In the next cycle lk_hit is 1, lk_stall is 0 and lk_desc equals that fill_desc. The slot's previous contents are lost.
- R6: lk_valid and lk_key have no effect while lk_stall is high. The pending key and the result of the pending lookup do not change.
- R7: A cycle with inv_all high makes every slot invalid from the next cycle on. The exception is a refill write in that same cycle, which takes precedence for its own slot.
- R8: A cycle with inv_one high clears the valid bit of the slot indexed by inv_key only if that slot is valid and its tag equals inv_key. A different key that maps to the same slot leaves the slot intact.
- R9: A cycle with upd_valid high replaces the descriptor of the slot indexed by upd_key with upd_desc only if that slot is valid and its tag equals upd_key. An update for a key that is not cached changes nothing and does not allocate a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_key | input | KEY_W | Lookup key (segment and page number) |
| lk_hit | output | 1 | Lookup result valid and hit |
| lk_desc | output | DESC_W | Descriptor returned with lk_hit |
| lk_stall | output | 1 | Lookup in progress on a miss; new requests ignored |
| fill_req | output | 1 | Refill request to descriptor memory |
| fill_key | output | KEY_W | Key whose descriptor is requested |
| fill_ack | input | 1 | Refill data valid |
| fill_desc | input | DESC_W | Refill descriptor |
| inv_all | input | 1 | Invalidate every slot |
| inv_one | input | 1 | Invalidate the slot holding inv_key |
| inv_key | input | KEY_W | Key for single-entry invalidation |
| upd_valid | input | 1 | Write-through descriptor update strobe |
| upd_key | input | KEY_W | Key of the updated descriptor |
| upd_desc | input | DESC_W | New descriptor value |

## Verification
The bench targets conflict pairs: two keys that fold to the same index. A design that indexed by the low key bits, or that compared only part of the tag, would return the other key's descriptor instead of missing. It issues single-key invalidations and updates with a conflicting key that shares the slot. A design that skipped the tag check would then wrongly drop or corrupt the resident entry, or allocate on an update. It also presents stray requests while a refill is pending, which catches a controller that overwrites its pending key. Finally, it checks that the descriptor returned right after a refill is the one just delivered, not stale slot contents.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_FILL  = 2'd2
    } dc_state_e;

    // fewest key bits any index bit folds together
    function automatic int min_fold(input int key_w, input int idx_w);
        return key_w / idx_w;
    endfunction

endpackage

// File: rtl/dcache_hash.sv
module dcache_hash
    import dcache_pkg::*;
#(
    parameter int KEY_W = 20,
    parameter int IDX_W = 4
) (
    input  logic [KEY_W-1:0] key,
    output logic [IDX_W-1:0] idx
);

    localparam int FOLD = min_fold(KEY_W, IDX_W);

    if (FOLD < 3) begin : g_bad_width
        $error("dcache_hash: key too narrow for three-bit folding");
    end

    for (genvar i = 0; i < IDX_W; i++) begin : g_bit
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int j = i; j < KEY_W; j += IDX_W) begin
                acc = acc ^ key[j];
            end
        end
        assign idx[i] = acc;
    end

endmodule

// File: rtl/dcache_table.sv
module dcache_table #(
    parameter int KEY_W  = 20,
    parameter int DESC_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [KEY_W-1:0]  rd_tag,
    output logic [DESC_W-1:0] rd_desc,
    input  logic              inv_all,
    input  logic              inv_one,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic [KEY_W-1:0]  inv_key,
    input  logic              upd_valid,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [KEY_W-1:0]  upd_key,
    input  logic [DESC_W-1:0] upd_desc,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [KEY_W-1:0]  fill_key,
    input  logic [DESC_W-1:0] fill_desc
);

    localparam int SLOTS = 1 << IDX_W;

    logic [SLOTS-1:0]  valid_q;
    logic [KEY_W-1:0]  tag_q  [SLOTS];
    logic [DESC_W-1:0] desc_q [SLOTS];

    logic inv_hit;
    logic upd_hit;

    assign inv_hit = inv_one && valid_q[inv_idx] && (tag_q[inv_idx] == inv_key);
    assign upd_hit = upd_valid && valid_q[upd_idx] && (tag_q[upd_idx] == upd_key);

    // valid bits: flush, then single clear, then refill wins
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (inv_all) begin
                valid_q <= '0;
            end
            if (inv_hit) begin
                valid_q[inv_idx] <= 1'b0;
            end
            if (fill_we) begin
                valid_q[fill_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (upd_hit) begin
            desc_q[upd_idx] <= upd_desc;
        end
        if (fill_we) begin
            tag_q[fill_idx]  <= fill_key;
            desc_q[fill_idx] <= fill_desc;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_desc  = desc_q[rd_idx];

    a_r7_flush_clears: assert property (@(posedge clk) disable iff (rst)
        (inv_all && !fill_we) |=> (valid_q == '0));

    a_r8_single_clear: assert property (@(posedge clk) disable iff (rst)
        (inv_hit && !(fill_we && fill_idx == inv_idx)) |=> !valid_q[$past(inv_idx)]);

    a_r9_write_through: assert property (@(posedge clk) disable iff (rst)
        (upd_hit && !(fill_we && fill_idx == upd_idx)) |=> (desc_q[$past(upd_idx)] == $past(upd_desc)));

    a_r5_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
        fill_we |=> valid_q[$past(fill_idx)]);

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
    import dcache_pkg::*;
#(
    parameter int KEY_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [KEY_W-1:0] lk_key,
    input  logic             slot_match,
    input  logic             fill_ack,
    output logic             lk_hit,
    output logic             lk_stall,
    output logic             fill_req,
    output logic             fill_we,
    output logic [KEY_W-1:0] pend_key
);

    dc_state_e st_q, st_n;
    logic      accept;

    always_comb begin
        lk_hit   = (st_q == ST_CHECK) && slot_match;
        lk_stall = ((st_q == ST_CHECK) && !slot_match) || (st_q == ST_FILL);
        fill_req = lk_stall;
        fill_we  = fill_req && fill_ack;
        accept   = lk_valid && !lk_stall;
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE:  st_n = accept ? ST_CHECK : ST_IDLE;
            ST_CHECK: begin
                if (slot_match) st_n = accept ? ST_CHECK : ST_IDLE;
                else            st_n = fill_ack ? ST_CHECK : ST_FILL;
            end
            ST_FILL:  st_n = fill_ack ? ST_CHECK : ST_FILL;
            default:  st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            pend_key <= '0;
        end else begin
            st_q <= st_n;
            if (accept) begin
                pend_key <= lk_key;
            end
        end
    end

    a_r6_key_held: assert property (@(posedge clk) disable iff (rst)
        lk_stall |=> $stable(pend_key));

    a_r3_hit_has_cause: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> ($past(accept) || $past(fill_we)));

endmodule

// File: rtl/desc_cache.sv
module desc_cache
    import dcache_pkg::*;
#(
    parameter int KEY_W  = 20,
    parameter int DESC_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [KEY_W-1:0]  lk_key,
    output logic              lk_hit,
    output logic [DESC_W-1:0] lk_desc,
    output logic              lk_stall,
    output logic              fill_req,
    output logic [KEY_W-1:0]  fill_key,
    input  logic              fill_ack,
    input  logic [DESC_W-1:0] fill_desc,
    input  logic              inv_all,
    input  logic              inv_one,
    input  logic [KEY_W-1:0]  inv_key,
    input  logic              upd_valid,
    input  logic [KEY_W-1:0]  upd_key,
    input  logic [DESC_W-1:0] upd_desc
);

    logic [KEY_W-1:0]  pend_key;
    logic [IDX_W-1:0]  pend_idx, inv_idx, upd_idx;
    logic              slot_valid, slot_match, fill_we;
    logic [KEY_W-1:0]  slot_tag;
    logic [DESC_W-1:0] slot_desc;

    dcache_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash_pend (.key(pend_key), .idx(pend_idx));
    dcache_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash_inv  (.key(inv_key),  .idx(inv_idx));
    dcache_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash_upd  (.key(upd_key),  .idx(upd_idx));

    dcache_table #(.KEY_W(KEY_W), .DESC_W(DESC_W), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (pend_idx),
        .rd_valid  (slot_valid),
        .rd_tag    (slot_tag),
        .rd_desc   (slot_desc),
        .inv_all   (inv_all),
        .inv_one   (inv_one),
        .inv_idx   (inv_idx),
        .inv_key   (inv_key),
        .upd_valid (upd_valid),
        .upd_idx   (upd_idx),
        .upd_key   (upd_key),
        .upd_desc  (upd_desc),
        .fill_we   (fill_we),
        .fill_idx  (pend_idx),
        .fill_key  (pend_key),
        .fill_desc (fill_desc)
    );

    assign slot_match = slot_valid && (slot_tag == pend_key);

    dcache_ctrl #(.KEY_W(KEY_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .lk_valid   (lk_valid),
        .lk_key     (lk_key),
        .slot_match (slot_match),
        .fill_ack   (fill_ack),
        .lk_hit     (lk_hit),
        .lk_stall   (lk_stall),
        .fill_req   (fill_req),
        .fill_we    (fill_we),
        .pend_key   (pend_key)
    );

    assign lk_desc  = slot_desc;
    assign fill_key = pend_key;

    a_r3_hit_xor_stall: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_stall));

    a_r4_refill_hold: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_ack) |=> (fill_req && lk_stall && $stable(fill_key)));

    a_r5_fill_returns: assert property (@(posedge clk) disable iff (rst)
        (fill_req && fill_ack) |=> (lk_hit && !lk_stall && lk_desc == $past(fill_desc)));

endmodule

// File: tb/desc_cache_test.sv
module desc_cache_test;

    localparam int PERIOD = 10;
    localparam int KW = 20;
    localparam int DW = 32;
    localparam int HW = 4;
    localparam int NS = 1 << HW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lk_valid = 1'b0, fill_ack = 1'b0, inv_all = 1'b0, inv_one = 1'b0, upd_valid = 1'b0;
    logic [KW-1:0] lk_key = '0, inv_key = '0, upd_key = '0;
    logic [DW-1:0] fill_desc = '0, upd_desc = '0;
    logic lk_hit, lk_stall, fill_req;
    logic [DW-1:0] lk_desc;
    logic [KW-1:0] fill_key;

    int total = 0;
    int fails = 0;

    bit            mvalid [NS];
    logic [KW-1:0] mtag   [NS];
    logic [DW-1:0] mdesc  [NS];
    logic [KW-1:0] pool   [24];

    always #(PERIOD/2) clk = ~clk;

    desc_cache #(.KEY_W(KW), .DESC_W(DW), .IDX_W(HW)) uut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_key(lk_key), .lk_hit(lk_hit), .lk_desc(lk_desc), .lk_stall(lk_stall),
        .fill_req(fill_req), .fill_key(fill_key), .fill_ack(fill_ack), .fill_desc(fill_desc),
        .inv_all(inv_all), .inv_one(inv_one), .inv_key(inv_key),
        .upd_valid(upd_valid), .upd_key(upd_key), .upd_desc(upd_desc)
    );

    function automatic int hsh(input logic [KW-1:0] k);
        logic [HW-1:0] h = '0;
        for (int j = 0; j < KW; j++) h[j % HW] = h[j % HW] ^ k[j];
        return int'(h);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [KW-1:0] key, input int ack_wait, input string req);
        int s = hsh(key);
        bit exp_hit = mvalid[s] && (mtag[s] == key);
        logic [DW-1:0] d;
        @(negedge clk); lk_valid = 1'b1; lk_key = key;
        @(negedge clk); lk_valid = 1'b0;
        if (exp_hit) begin
            check(lk_hit === 1'b1 && lk_stall === 1'b0, {req, "/R3 hit"}, {lk_hit, lk_stall}, 2'b10);
            check(lk_desc === mdesc[s], {req, "/R3 desc"}, lk_desc, mdesc[s]);
        end else begin
            check(lk_stall === 1'b1 && lk_hit === 1'b0 && fill_req === 1'b1, {req, "/R4 miss"},
                  {lk_hit, lk_stall, fill_req}, 3'b011);
            check(fill_key === key, {req, "/R4 key"}, fill_key, key);
            for (int w = 0; w < ack_wait; w++) begin
                lk_valid = 1'b1; lk_key = ~key;   // stray request, R6
                @(negedge clk); lk_valid = 1'b0;
                check(lk_stall === 1'b1 && fill_req === 1'b1 && fill_key === key, "R6 stray ignored",
                      fill_key, key);
            end
            d = $urandom;
            fill_ack = 1'b1; fill_desc = d;
            @(negedge clk); fill_ack = 1'b0;
            check(lk_hit === 1'b1 && lk_stall === 1'b0 && lk_desc === d, {req, "/R5 refill"},
                  {lk_hit, lk_stall, lk_desc}, {2'b10, d});
            mvalid[s] = 1'b1; mtag[s] = key; mdesc[s] = d;
        end
    endtask

    task automatic flush_all();
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
        for (int s = 0; s < NS; s++) mvalid[s] = 1'b0;
    endtask

    task automatic inval_one(input logic [KW-1:0] key);
        int s = hsh(key);
        @(negedge clk); inv_one = 1'b1; inv_key = key;
        @(negedge clk); inv_one = 1'b0;
        if (mvalid[s] && mtag[s] == key) mvalid[s] = 1'b0;
    endtask

    task automatic update(input logic [KW-1:0] key, input logic [DW-1:0] d);
        int s = hsh(key);
        @(negedge clk); upd_valid = 1'b1; upd_key = key; upd_desc = d;
        @(negedge clk); upd_valid = 1'b0;
        if (mvalid[s] && mtag[s] == key) mdesc[s] = d;
    endtask

    initial begin
        #(PERIOD * 150000);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [KW-1:0] ka, kb, kc;
        void'($urandom(32'h5eed_0042));
        for (int s = 0; s < NS; s++) mvalid[s] = 1'b0;
        for (int i = 0; i < 24; i++) pool[i] = KW'($urandom);

        repeat (3) @(negedge clk);
        check(lk_hit === 1'b0 && lk_stall === 1'b0 && fill_req === 1'b0, "R1 in reset",
              {lk_hit, lk_stall, fill_req}, 3'b000);
        rst = 1'b0;
        @(negedge clk);
        check(lk_hit === 1'b0 && lk_stall === 1'b0 && fill_req === 1'b0, "R1 after reset",
              {lk_hit, lk_stall, fill_req}, 3'b000);

        // R1: first lookup misses
        ka = 20'h1_2345;
        lookup(ka, 0, "R1 cold");
        lookup(ka, 0, "R3 rehit");

        // R2: conflict pair (same fold) evicts; flipping bits 0 and HW keeps the index
        kb = ka ^ KW'(1) ^ (KW'(1) << HW);
        check(hsh(kb) == hsh(ka), "R2 bench pair", hsh(kb), hsh(ka));
        lookup(kb, 2, "R2 conflict");
        lookup(ka, 1, "R2 evicted");
        kc = ka ^ KW'(1);   // different index
        lookup(kc, 0, "R2 distinct");
        lookup(ka, 0, "R2 coexist");

        // R8: conflicting key does not clear; matching key does
        inval_one(kb);
        lookup(ka, 0, "R8 mismatch keeps");
        inval_one(ka);
        lookup(ka, 0, "R8 cleared");

        // R9: write-through on match; ignored on conflicting and absent keys
        update(ka, 32'hdead_beef);
        lookup(ka, 0, "R9 updated");
        update(kb, 32'h0bad_0bad);
        lookup(ka, 0, "R9 mismatch ignored");
        update(20'h0_0000, 32'h1111_2222);
        lookup(20'h0_0000, 0, "R9 no allocate");

        // R7: flush
        flush_all();
        lookup(kc, 0, "R7 flushed");
        lookup(ka, 3, "R7 flushed2");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 99);
            logic [KW-1:0] k = pool[$urandom_range(0, 23)];
            if (op < 65)      lookup(k, $urandom_range(0, 3), "rand");
            else if (op < 82) update(k, $urandom);
            else if (op < 96) inval_one(k);
            else              flush_all();
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule